// File: doc/BRIEF.md
# Serial Autoflow Control Unit

This block adds hardware flow control to a UART whose receive and transmit paths use 16-entry FIFOs. On the receive side it drives the request-to-send line from the receive FIFO occupancy. Once the FIFO fill reaches a programmable trigger level, RTS is withdrawn. RTS comes back only after software has drained the FIFO completely. On the transmit side it samples the clear-to-send line through a two-stage synchronizer. It then grants or withholds permission for the transmitter sequencer to begin the next character.

Both automatic functions apply only while the FIFOs are enabled. Each one has its own enable. In character (non-FIFO) mode, and whenever an automatic function is switched off, RTS is the plain software bit and the transmitter is always permitted. The FIFOs, shifters and register decoding sit outside this block. They connect through the occupancy count, the busy flag and the control inputs.

Top module: `uart_autoflow`

## Requirements
- R1: While reset is applied and for the cycles that follow it, `rts_out` is 0. With automatic CTS disabled, `tx_permit` is 1.
- R2: When `fifo_en` is 0, the automatic enables have no effect. `rts_out` equals `sw_rts` one cycle later, and `tx_permit` is 1 regardless of `cts_in`.
- R3: With `fifo_en`, `auto_rts_en` and `sw_rts` all 1, `rts_out` falls one cycle after `rx_count` reaches the trigger level. The trigger level is set by `trig_sel`: 0 selects 1 entry, 1 selects 4, 2 selects 8 and 3 selects 14.
- R4: Once RTS has been withdrawn by the trigger, it stays at 0 while `rx_count` is nonzero, even below the level. It returns to 1 one cycle after `rx_count` is 0.
- R5: When `sw_rts` is 0, `rts_out` is 0 one cycle later, whatever the automatic state.
- R6: With `fifo_en` 1 and `auto_rts_en` 0, `rts_out` follows `sw_rts` one cycle later, even with a full receive FIFO (count 16).
- R7: With `fifo_en` and `auto_cts_en` both 1 and `tx_busy` 0, `tx_permit` equals `cts_in` as sampled two clock edges earlier. If either enable is 0, `tx_permit` is 1.
- R8: A change on `cts_in` reaches `tx_permit` only after two clock edges. After a single edge, the old value still shows.
- R9: While `tx_busy` is 1, `tx_permit` is 1, so a character that is already in progress is never cut off by CTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_count | input | 5 | Receive FIFO occupancy, 0 to 16 |
| trig_sel | input | 2 | Trigger level code (1, 4, 8, 14 entries) |
| fifo_en | input | 1 | FIFO mode enable |
| auto_rts_en | input | 1 | Automatic RTS enable |
| auto_cts_en | input | 1 | Automatic CTS enable |
| sw_rts | input | 1 | Software RTS bit, 1 = request |
| cts_in | input | 1 | Clear-to-send line, 1 = clear, asynchronous |
| tx_busy | input | 1 | Transmitter is shifting a character |
| rts_out | output | 1 | Request-to-send line, 1 = request |
| tx_permit | output | 1 | Transmitter may start a character |

## Verification
The properties assume that `rx_count` never exceeds 16. They also assume that `trig_sel` is held steady while RTS is withdrawn, so the hysteresis band is well defined. The CTS latency property assumes that `cts_in` is settled around the sampling edge. The stimulus keeps `rx_count` in range and changes `trig_sel` only after the FIFO has been drained. It also drives every input half a period away from the rising edge.

// File: rtl/autoflow_pkg.sv
package autoflow_pkg;

  localparam int unsigned FIFO_DEPTH = 16;
  localparam int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1);

  typedef logic [CNT_W-1:0] fill_t;

  typedef enum logic [1:0] {
    TRIG_ONE   = 2'd0,
    TRIG_FOUR  = 2'd1,
    TRIG_EIGHT = 2'd2,
    TRIG_HIGH  = 2'd3
  } trig_code_e;

  // Occupancy at which RTS is withdrawn; the top level tracks the depth.
  function automatic fill_t trig_level(input trig_code_e code);
    fill_t lvl;
    case (code)
      TRIG_ONE:   lvl = fill_t'(1);
      TRIG_FOUR:  lvl = fill_t'(FIFO_DEPTH / 4);
      TRIG_EIGHT: lvl = fill_t'(FIFO_DEPTH / 2);
      default:    lvl = fill_t'(FIFO_DEPTH - 2);
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/af_sync.sv
module af_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = d_async;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_comb chain_d[i] = chain_q[i-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/af_rts_ctrl.sv
module af_rts_ctrl
  import autoflow_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       auto_on,
  input  logic       sw_rts,
  input  fill_t      rx_count,
  input  trig_code_e trig_sel,
  output logic       rts_out
);

  logic  hold_q, hold_d;
  logic  rts_q, rts_d;
  fill_t level;
  logic  at_level;
  logic  drained;

  always_comb begin
    level    = trig_level(trig_sel);
    at_level = (rx_count >= level);
    drained  = (rx_count == '0);
  end

  // Hold flag: set at the trigger, cleared only once the FIFO is empty.
  always_comb begin
    hold_d = hold_q;
    if (!auto_on)      hold_d = 1'b0;
    else if (at_level) hold_d = 1'b1;
    else if (drained)  hold_d = 1'b0;
  end

  always_comb begin
    rts_d = sw_rts & ~(auto_on & hold_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      rts_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      rts_q  <= rts_d;
    end
  end

  assign rts_out = rts_q;

endmodule

// File: rtl/af_tx_gate.sv
module af_tx_gate (
  input  logic auto_on,
  input  logic cts_ok,
  input  logic tx_busy,
  output logic tx_permit
);

  always_comb begin
    tx_permit = tx_busy | ~auto_on | cts_ok;
  end

endmodule

// File: rtl/uart_autoflow.sv
module uart_autoflow
  import autoflow_pkg::*;
#(
  parameter int unsigned CTS_STAGES = 2,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [1:0]       trig_sel,
  input  logic             fifo_en,
  input  logic             auto_rts_en,
  input  logic             auto_cts_en,
  input  logic             sw_rts,
  input  logic             cts_in,
  input  logic             tx_busy,
  output logic             rts_out,
  output logic             tx_permit
);

  logic rst_sync_n;
  logic cts_ok;
  logic auto_rts_on;
  logic auto_cts_on;

  // Reset asserts at once and releases on a clock edge.
  af_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (1'b1),
    .q_sync  (rst_sync_n)
  );

  always_comb begin
    auto_rts_on = fifo_en & auto_rts_en;
    auto_cts_on = fifo_en & auto_cts_en;
  end

  af_sync #(.STAGES(CTS_STAGES), .RST_VAL(1'b0)) u_cts_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .d_async (cts_in),
    .q_sync  (cts_ok)
  );

  af_rts_ctrl u_rts (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .auto_on  (auto_rts_on),
    .sw_rts   (sw_rts),
    .rx_count (fill_t'(rx_count)),
    .trig_sel (trig_code_e'(trig_sel)),
    .rts_out  (rts_out)
  );

  af_tx_gate u_gate (
    .auto_on   (auto_cts_on),
    .cts_ok    (cts_ok),
    .tx_busy   (tx_busy),
    .tx_permit (tx_permit)
  );

endmodule

// File: rtl/uart_autoflow_chk.sv
module uart_autoflow_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic [4:0] rx_count,
  input logic [1:0] trig_sel,
  input logic       fifo_en,
  input logic       auto_rts_en,
  input logic       auto_cts_en,
  input logic       sw_rts,
  input logic       cts_in,
  input logic       tx_busy,
  input logic       rts_out,
  input logic       tx_permit
);

  logic [4:0] exp_lvl;
  always_comb begin
    case (trig_sel)
      2'd0:    exp_lvl = 5'd1;
      2'd1:    exp_lvl = 5'd4;
      2'd2:    exp_lvl = 5'd8;
      default: exp_lvl = 5'd14;
    endcase
  end

  a_r2_char_mode_rts: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !fifo_en |=> (rts_out == $past(sw_rts)));

  a_r3_trigger_drop: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fifo_en && auto_rts_en && rx_count >= exp_lvl) |=> !rts_out);

  a_r5_sw_off: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sw_rts |=> !rts_out);

  a_r7_no_auto_cts: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(fifo_en && auto_cts_en) |-> tx_permit);

  a_r8_cts_latency: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fifo_en && auto_cts_en && !tx_busy && tx_permit) |-> $past(cts_in, 2));

  a_r9_busy_keeps: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_busy |-> tx_permit);

endmodule

bind uart_autoflow uart_autoflow_chk u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .rx_count    (rx_count),
  .trig_sel    (trig_sel),
  .fifo_en     (fifo_en),
  .auto_rts_en (auto_rts_en),
  .auto_cts_en (auto_cts_en),
  .sw_rts      (sw_rts),
  .cts_in      (cts_in),
  .tx_busy     (tx_busy),
  .rts_out     (rts_out),
  .tx_permit   (tx_permit)
);

// File: tb/sim_uart_autoflow.sv
`timescale 1ns/1ps
module sim_uart_autoflow;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] rx_count;
  logic [1:0] trig_sel;
  logic       fifo_en, auto_rts_en, auto_cts_en, sw_rts, cts_in, tx_busy;
  logic       rts_out, tx_permit;

  int cyc = 0;
  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  typedef struct {
    int    due;
    bit    is_permit;
    logic  exp;
    string req;
  } item_t;

  item_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_autoflow u0 (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .trig_sel(trig_sel),
    .fifo_en(fifo_en), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
    .sw_rts(sw_rts), .cts_in(cts_in), .tx_busy(tx_busy),
    .rts_out(rts_out), .tx_permit(tx_permit)
  );

  // Monitor: compare results as they fall due.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      logic  act;
      it  = sb.pop_front();
      act = it.is_permit ? tx_permit : rts_out;
      n_checks++;
      if (act !== it.exp) begin
        n_errors++;
        $display("FAIL %s: %s actual %b expected %b at cycle %0d",
                 it.req, it.is_permit ? "tx_permit" : "rts_out", act, it.exp, cyc);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic expect_at(input int dly, input bit is_p, input logic e, input string req);
    item_t it;
    it.due = cyc + dly;
    it.is_permit = is_p;
    it.exp = e;
    it.req = req;
    sb.push_back(it);
  endtask

  task automatic set_count(input int c, input logic e_rts, input string req);
    step();
    rx_count = 5'(c);
    expect_at(1, 0, e_rts, req);
    step();
  endtask

  initial begin
    rst_n = 1'b0; rx_count = '0; trig_sel = 2'd0; fifo_en = 0;
    auto_rts_en = 0; auto_cts_en = 0; sw_rts = 1; cts_in = 1; tx_busy = 0;
    repeat (3) step();
    expect_at(0, 0, 1'b0, "R1");
    expect_at(0, 1, 1'b1, "R1");
    step();
    rst_n = 1'b1;
    expect_at(1, 0, 1'b0, "R1");
    repeat (6) step();

    // R2: character mode ignores automatic enables
    fifo_en = 0; auto_rts_en = 1; auto_cts_en = 1; sw_rts = 1; cts_in = 0; rx_count = 5'd16;
    expect_at(3, 0, 1'b1, "R2");
    expect_at(3, 1, 1'b1, "R2");
    repeat (4) step();

    // R3 / R4: trigger level 4
    fifo_en = 1; auto_cts_en = 0; trig_sel = 2'd1; rx_count = 0;
    repeat (2) step();
    set_count(3, 1'b1, "R3");
    set_count(4, 1'b0, "R3");
    set_count(2, 1'b0, "R4");
    set_count(0, 1'b1, "R4");
    // level 1
    trig_sel = 2'd0;
    set_count(1, 1'b0, "R3");
    set_count(0, 1'b1, "R4");
    // level 8
    trig_sel = 2'd2;
    set_count(7, 1'b1, "R3");
    set_count(8, 1'b0, "R3");
    set_count(5, 1'b0, "R4");
    set_count(0, 1'b1, "R4");
    // level 14
    trig_sel = 2'd3;
    set_count(13, 1'b1, "R3");
    set_count(14, 1'b0, "R3");
    set_count(1, 1'b0, "R4");
    set_count(0, 1'b1, "R4");

    // R5: software bit low wins
    step(); sw_rts = 0; expect_at(1, 0, 1'b0, "R5"); step();
    step(); sw_rts = 1; expect_at(1, 0, 1'b1, "R5"); step();

    // R6: auto-RTS off, FIFO full
    step(); auto_rts_en = 0; rx_count = 5'd16; expect_at(1, 0, 1'b1, "R6"); step();
    step(); sw_rts = 0; expect_at(1, 0, 1'b0, "R6"); step();
    rx_count = 0; sw_rts = 1;

    // R7 / R8: CTS gating with sync latency
    step(); auto_cts_en = 1; cts_in = 1; repeat (3) step();
    cts_in = 0;
    expect_at(1, 1, 1'b1, "R8");
    expect_at(2, 1, 1'b0, "R7");
    repeat (4) step();
    // R9: busy keeps permit while CTS is low
    tx_busy = 1; expect_at(1, 1, 1'b1, "R9");
    repeat (2) step();
    tx_busy = 0; expect_at(1, 1, 1'b0, "R9");
    repeat (2) step();
    cts_in = 1;
    expect_at(1, 1, 1'b0, "R8");
    expect_at(2, 1, 1'b1, "R7");
    repeat (4) step();
    // R7: auto-CTS off releases the transmitter
    cts_in = 0; auto_cts_en = 0;
    expect_at(3, 1, 1'b1, "R7");
    repeat (5) step();

    done = 1;
  end

  initial begin
    wait (done || cyc > 100000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule